// File: doc/BRIEF.md
# Two-Master Bus Arbiter with Burst Cap

This block decides which of two masters, a CPU core or a DMA engine, drives a shared bus. The CPU holds the bus whenever nobody asks for it. A master asks by raising its request and keeps that request high for as long as it needs the bus. It gives the bus back by lowering the request. When the ownership decision is open, the DMA engine wins over the CPU. While the current owner keeps its request high, the other master cannot take the bus.

Every ownership period, or tenure, is limited by a count of halfword beats, which the owner reports on `beat`. A CPU tenure, and a DMA tenure serving an external requester, may carry at most `MAX_BURST` beats (8 by default). A DMA tenure serving an internal peripheral may carry at most `INT_BURST` beats (5 by default). The beat that reaches the cap ends the tenure even if the request stays high. Whenever the bus is released or taken away, one dead cycle with neither grant active follows before the next grant. This holds even when the same master wins again.

The controller has three states: `ST_CPU` (CPU granted), `ST_DMA` (DMA granted) and `ST_DEAD` (no grant). The transitions are:
- `ST_CPU -> ST_DEAD` when the cap is reached, or when the CPU is not requesting and the DMA is.
- `ST_DMA -> ST_DEAD` when the cap is reached, or when the DMA request drops.
- `ST_DEAD -> ST_DMA` if the DMA is requesting.
- `ST_DEAD -> ST_CPU` otherwise.
- Every other case stays in the current state.

The grants are registered copies of the state. The DMA source kind (`dma_int`) is sampled during the dead cycle that leads into `ST_DMA`.

Top module: `bus_owner_arb`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, cpu_gnt=1 and dma_gnt=0, with no dead cycle.
- R2: cpu_gnt and dma_gnt are never both 1.
- R3: With no request from either master, cpu_gnt stays 1.
- R4: If dma_req=1 while the CPU owns the bus and cpu_req=0, then after the next clock edge both grants are 0. After the edge that follows, dma_gnt=1.
- R5: While the CPU owns the bus with cpu_req=1 and the cap is not reached, dma_req does not take the bus away from the CPU.
- R6: When the DMA drops dma_req, one dead cycle follows, then cpu_gnt=1 if dma_req is still 0.
- R7: A CPU tenure ends after its 8th counted beat, even with cpu_req held at 1.
- R8: A DMA tenure with dma_int=0 sampled in its dead cycle ends after its 8th beat.
- R9: A DMA tenure with dma_int=1 sampled in its dead cycle ends after its 5th beat.
- R10: After any dead cycle, the DMA is granted if dma_req=1. Otherwise the CPU is granted, including the master that was just capped.
- R11: A beat while the CPU holds the bus only by default (cpu_req=0) is not counted, and it restarts the CPU's count.
- R12: Every change of grant passes through exactly one cycle with both grants 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | CPU bus request, held for the whole tenure |
| dma_req | input | 1 | DMA bus request, held for the whole tenure |
| dma_int | input | 1 | 1 when the DMA request comes from an internal peripheral (short cap) |
| beat | input | 1 | One halfword transfer by the current owner this cycle |
| cpu_gnt | output | 1 | CPU owns the bus (registered) |
| dma_gnt | output | 1 | DMA owns the bus (registered) |

## Verification
The main path is driven with several request patterns:
- A DMA request against an idle default owner, which separates preemption of a non-requesting CPU from a blocked handover.
- Simultaneous requests while the CPU holds its request, which shows whether priority is wrongly applied inside a tenure.
- Long beat runs from both masters with both DMA source kinds, which tells the 5-beat cap apart from the 8-beat cap and shows which master is regranted after a forced release.

A beat issued while the CPU owns the bus without requesting, placed between two counted runs, shows whether such a beat is counted or clears the count. A reset applied mid-tenure checks that the CPU is granted at once.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ST_CPU  = 2'd0,
        ST_DEAD = 2'd1,
        ST_DMA  = 2'd2
    } own_st_e;
endpackage

// File: rtl/arb_cap_sel.sv
module arb_cap_sel #(
    parameter int MAX_BURST = 8,
    parameter int INT_BURST = 5,
    parameter int CW        = $clog2(MAX_BURST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,   // dead cycle that leads into a DMA tenure
    input  logic          dma_int,
    input  logic          dma_own,
    output logic [CW-1:0] cap
);
    localparam logic [CW-1:0] CAP_LONG  = CW'(MAX_BURST);
    localparam logic [CW-1:0] CAP_SHORT = CW'(INT_BURST);

    logic src_int_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            src_int_q <= 1'b0;
        else if (capture)
            src_int_q <= dma_int;
    end

    always_comb begin
        cap = CAP_LONG;
        if (dma_own && src_int_q)
            cap = CAP_SHORT;
    end

    // R9: the short cap only ever applies to a DMA tenure
    p_short_cap_dma_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap == CAP_SHORT && CAP_SHORT != CAP_LONG) |-> dma_own);
endmodule

// File: rtl/arb_beat_ctr.sv
module arb_beat_ctr #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] cap,
    output logic          last
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;

    assign cnt_nx = cnt_q + 1'b1;
    assign last   = inc && (cnt_nx == cap);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || last)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_nx;
    end

    // R7: the count of a tenure never reaches the cap without ending it
    p_cnt_below_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < cap);
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cpu_req,
    input  logic    dma_req,
    input  logic    last,
    output own_st_e st,
    output logic    cpu_gnt,
    output logic    dma_gnt
);
    own_st_e st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_CPU:  if (last || (!cpu_req && dma_req)) st_nx = ST_DEAD;
            ST_DMA:  if (last || !dma_req)              st_nx = ST_DEAD;
            ST_DEAD: st_nx = dma_req ? ST_DMA : ST_CPU;
            default: st_nx = ST_DEAD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_CPU;
        else
            st <= st_nx;
    end

    // registered grants
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_gnt <= 1'b1;
            dma_gnt <= 1'b0;
        end else begin
            cpu_gnt <= (st_nx == ST_CPU);
            dma_gnt <= (st_nx == ST_DMA);
        end
    end

    p_one_gnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_gnt && dma_gnt));

    p_dead_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_gnt && !dma_gnt) |=> (cpu_gnt || dma_gnt));

    p_cpu_after_dead_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_gnt) |-> $past(!dma_gnt));

    p_dma_after_dead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_gnt) |-> $past(!cpu_gnt));

    p_cpu_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_gnt && cpu_req && !last) |=> cpu_gnt);
endmodule

// File: rtl/bus_owner_arb.sv
module bus_owner_arb
    import arb_pkg::*;
#(
    parameter int MAX_BURST = 8,
    parameter int INT_BURST = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic dma_req,
    input  logic dma_int,
    input  logic beat,
    output logic cpu_gnt,
    output logic dma_gnt
);
    localparam int CW = $clog2(MAX_BURST + 1);

    own_st_e       st;
    logic [CW-1:0] cap;
    logic          last;
    logic          clr;
    logic          inc;

    // a default CPU tenure without request counts nothing and restarts
    assign clr = (st == ST_DEAD) || (st == ST_CPU && !cpu_req);
    assign inc = beat && ((st == ST_CPU && cpu_req) || (st == ST_DMA && dma_req));

    arb_cap_sel #(.MAX_BURST(MAX_BURST), .INT_BURST(INT_BURST), .CW(CW)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (st == ST_DEAD && dma_req),
        .dma_int (dma_int),
        .dma_own (st == ST_DMA),
        .cap     (cap)
    );

    arb_beat_ctr #(.CW(CW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (inc),
        .cap   (cap),
        .last  (last)
    );

    arb_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_req (cpu_req),
        .dma_req (dma_req),
        .last    (last),
        .st      (st),
        .cpu_gnt (cpu_gnt),
        .dma_gnt (dma_gnt)
    );
endmodule

// File: tb/sim_bus_owner_arb.sv
module sim_bus_owner_arb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, dma_req = 1'b0, dma_int = 1'b0, beat = 1'b0;
    logic cpu_gnt, dma_gnt;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bus_owner_arb u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .dma_req(dma_req),
        .dma_int(dma_int), .beat(beat), .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt)
    );

    // {tag, cpu_req, dma_req, dma_int, beat, exp cpu_gnt, exp dma_gnt}
    localparam int NV = 44;
    localparam logic [9:0] VEC [0:NV-1] = '{
        {4'd3,  6'b0000_10}, // R3 idle default owner
        {4'd4,  6'b0100_00}, // R4 dead cycle
        {4'd4,  6'b0100_01}, // R4 dma granted, external source
        {4'd6,  6'b0000_00}, // R6 dma released
        {4'd6,  6'b0000_10},
        {4'd5,  6'b1101_10}, // R5 cpu holds
        {4'd5,  6'b1101_10},
        {4'd12, 6'b0100_00}, // R12 cpu drops
        {4'd9,  6'b0110_01}, // R9 internal source
        {4'd9,  6'b0101_01},
        {4'd9,  6'b0101_01},
        {4'd9,  6'b0101_01},
        {4'd9,  6'b0101_01},
        {4'd9,  6'b0101_00}, // R9 5th beat
        {4'd10, 6'b0100_01}, // R10 dma regranted, external
        {4'd8,  6'b0101_01},
        {4'd8,  6'b0101_01},
        {4'd8,  6'b0101_01},
        {4'd8,  6'b0101_01},
        {4'd8,  6'b0101_01},
        {4'd8,  6'b0101_01},
        {4'd8,  6'b0101_01},
        {4'd8,  6'b0101_00}, // R8 8th beat
        {4'd10, 6'b1000_10}, // R10 cpu
        {4'd7,  6'b1001_10},
        {4'd7,  6'b1001_10},
        {4'd7,  6'b1001_10},
        {4'd7,  6'b1001_10},
        {4'd7,  6'b1001_10},
        {4'd7,  6'b1001_10},
        {4'd7,  6'b1001_10},
        {4'd7,  6'b1001_00}, // R7 8th beat
        {4'd10, 6'b1000_10}, // R10 capped cpu regranted
        {4'd11, 6'b1001_10}, // one counted beat
        {4'd11, 6'b0001_10}, // R11 ignored, clears
        {4'd11, 6'b1001_10},
        {4'd11, 6'b1001_10},
        {4'd11, 6'b1001_10},
        {4'd11, 6'b1001_10},
        {4'd11, 6'b1001_10},
        {4'd11, 6'b1001_10},
        {4'd11, 6'b1001_10}, // 7 beats since clear
        {4'd11, 6'b1001_00}, // 8th ends tenure
        {4'd3,  6'b0000_10}
    };

    task automatic chk(input string tag, input logic ac, input logic ad,
                       input logic ec, input logic ed);
        total++;
        if (ac !== ec || ad !== ed) begin
            bad++;
            $display("FAIL %s: cpu_gnt=%b dma_gnt=%b expected %b %b", tag, ac, ad, ec, ed);
        end
    endtask

    // R2 monitor
    always @(negedge clk) begin
        if (rst_n && cpu_gnt === 1'b1 && dma_gnt === 1'b1) begin
            total++;
            bad++;
            $display("FAIL R2: cpu_gnt=1 dma_gnt=1 expected at most one");
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 in reset", cpu_gnt, dma_gnt, 1'b1, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", cpu_gnt, dma_gnt, 1'b1, 1'b0);
        for (int i = 0; i < NV; i++) begin
            {cpu_req, dma_req, dma_int, beat} = VEC[i][5:2];
            @(negedge clk);
            chk($sformatf("R%0d vec%0d", VEC[i][9:6], i), cpu_gnt, dma_gnt,
                VEC[i][1], VEC[i][0]);
        end
        // R1: reset in the middle of a DMA tenure
        {cpu_req, dma_req, dma_int, beat} = 4'b0100;
        repeat (2) @(negedge clk);
        chk("R1 dma before reset", cpu_gnt, dma_gnt, 1'b0, 1'b1);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset", cpu_gnt, dma_gnt, 1'b1, 1'b0);
        {cpu_req, dma_req} = 2'b10;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cpu kept after reset", cpu_gnt, dma_gnt, 1'b1, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: run did not end, expected completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule